// File: doc/BRIEF.md
# Program Counter with Two-Entry Return Stack

This block generates the fetch address for a small core whose program space holds 1K words, split into two pages of 512 words. Each clock it either holds the current address, advances it by one, or loads it from a branch source: the operand field of a jump, the operand field of a subroutine call, the top of a two-entry return stack, or a byte from the data bus written to the low byte of the counter. The page-select bit provides the top address bit for every load. Calls and computed writes always clear address bit 8, so they can only reach the lower 256 words of a page.

The return stack keeps exactly two entries and reports no overflow or underflow. A third nested call drops the oldest return address. A return whose stack has run dry keeps producing the address left in the deeper entry. A return also hands its 8-bit literal to a working-register output with a one-cycle valid strobe. Every load of a new address raises a flush request in the next cycle, so the pipeline can discard the instruction it has already fetched.

Top module: `pc_seq`

## Requirements
- R1: While reset is asserted and right after it is released, fetch_addr is 3FFh, flush and w_lit_vld are 0, and both stack entries hold 000h.
- R2: With adv high and no branch control asserted, fetch_addr increments by one per cycle, and 3FFh rolls over to 000h. With no control asserted, fetch_addr holds its value.
- R3: A jump (do_goto) loads fetch_addr bits 8:0 from op_field bits 8:0 and bit 9 from page_sel.
- R4: A call (do_call) loads bits 7:0 from op_field bits 7:0, clears bit 8 and takes bit 9 from page_sel. The call moves stack entry 1 into entry 2 and writes fetch_addr+1 (modulo 1K) into entry 1.
- R5: A low-byte write (do_pcl_wr) loads bits 7:0 from dbus, clears bit 8 and takes bit 9 from page_sel, and leaves both stack entries unchanged.
- R6: A return (do_ret) loads fetch_addr from stack entry 1 and copies entry 2 into entry 1. Entry 2 keeps its value, so repeated returns keep yielding that address.
- R7: After more than two nested calls, only the two most recent return addresses remain on the stack.
- R8: A return drives op_field bits 7:0 onto w_lit in the next cycle, with w_lit_vld high for that one cycle only.
- R9: flush is high in the cycle after any jump, call, return or low-byte write, and low in the cycle after any other cycle.
- R10: When several controls are asserted together, the one taking effect is chosen in this order: do_goto, then do_call, then do_ret, then do_pcl_wr, then adv. A control that loses has no effect on the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv | input | 1 | Advance to the next sequential word |
| do_goto | input | 1 | Jump using the 9-bit operand |
| do_call | input | 1 | Subroutine call using the 8-bit operand |
| do_ret | input | 1 | Return with literal |
| do_pcl_wr | input | 1 | Write of the data bus to the counter low byte |
| op_field | input | 9 | Operand field of the instruction word |
| page_sel | input | 1 | Page-select bit, forms address bit 9 on loads |
| dbus | input | 8 | Data bus value for low-byte writes |
| fetch_addr | output | 10 | Current fetch address |
| flush | output | 1 | Discard the already-fetched instruction |
| w_lit | output | 8 | Literal delivered by a return |
| w_lit_vld | output | 1 | w_lit carries a new value this cycle |

## Verification
The stack entries are not visible at the ports, so the hardest cases to reach are overflow after a third nested call and the duplicated deep entry after the stack runs dry. The stimulus builds a three-deep call chain, then unwinds it with one return more than the stack holds, and reads each popped address from fetch_addr. The contention cases assert several controls at once and follow each with a return. That return shows whether a losing call still pushed an address, or whether a low-byte write disturbed the stack.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    // Source chosen for the next fetch address
    typedef enum logic [2:0] {
        SRC_HOLD = 3'd0,
        SRC_INC  = 3'd1,
        SRC_JMP  = 3'd2,
        SRC_SUB  = 3'd3,
        SRC_RTN  = 3'd4,
        SRC_LOW  = 3'd5
    } nxt_src_e;

endpackage

// File: rtl/pc_seq_arb.sv
module pc_seq_arb
    import pc_seq_pkg::*;
(
    input  logic     adv,
    input  logic     do_goto,
    input  logic     do_call,
    input  logic     do_ret,
    input  logic     do_pcl_wr,
    output nxt_src_e src,
    output logic     push,
    output logic     pop,
    output logic     redirect
);

    // Fixed priority: jump, call, return, low-byte write, advance
    always_comb begin
        src = SRC_HOLD;
        if (do_goto)        src = SRC_JMP;
        else if (do_call)   src = SRC_SUB;
        else if (do_ret)    src = SRC_RTN;
        else if (do_pcl_wr) src = SRC_LOW;
        else if (adv)       src = SRC_INC;
    end

    assign push     = (src == SRC_SUB);
    assign pop      = (src == SRC_RTN);
    assign redirect = (src == SRC_JMP) || (src == SRC_SUB) ||
                      (src == SRC_RTN) || (src == SRC_LOW);

endmodule

// File: rtl/pc_seq_stack.sv
module pc_seq_stack #(
    parameter int DEPTH  = 2,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] push_val,
    output logic [ADDR_W-1:0] top
);

    localparam int LAST = DEPTH - 1;

    logic [ADDR_W-1:0] lvl_d [DEPTH];
    logic [ADDR_W-1:0] lvl_q [DEPTH];

    // Push shifts every entry one deeper and drops the deepest one.
    // Pop shifts entries up; the deepest entry keeps its value.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) lvl_d[i] = lvl_q[i];
        if (push) begin
            lvl_d[0] = push_val;
            for (int i = 1; i < DEPTH; i++) lvl_d[i] = lvl_q[i-1];
        end else if (pop) begin
            for (int i = 0; i < LAST; i++) lvl_d[i] = lvl_q[i+1];
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q[g] <= '0;
            else        lvl_q[g] <= lvl_d[g];
        end
    end

    assign top = lvl_q[0];

endmodule

// File: rtl/pc_seq_target.sv
module pc_seq_target
    import pc_seq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LIT_W  = 8
) (
    input  nxt_src_e          src,
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-2:0] op_field,
    input  logic              page_sel,
    input  logic [LIT_W-1:0]  dbus,
    input  logic [ADDR_W-1:0] ret_addr,
    output logic [ADDR_W-1:0] nxt
);

    // Bits between the literal and the page bit are forced to zero
    localparam int FILL_W = ADDR_W - 1 - LIT_W;

    always_comb begin
        unique case (src)
            SRC_INC: nxt = cur + 1'b1;
            SRC_JMP: nxt = {page_sel, op_field};
            SRC_SUB: nxt = {page_sel, {FILL_W{1'b0}}, op_field[LIT_W-1:0]};
            SRC_RTN: nxt = ret_addr;
            SRC_LOW: nxt = {page_sel, {FILL_W{1'b0}}, dbus};
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/pc_seq.sv
module pc_seq
    import pc_seq_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int LIT_W     = 8,
    parameter int STK_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              do_goto,
    input  logic              do_call,
    input  logic              do_ret,
    input  logic              do_pcl_wr,
    input  logic [ADDR_W-2:0] op_field,
    input  logic              page_sel,
    input  logic [LIT_W-1:0]  dbus,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              flush,
    output logic [LIT_W-1:0]  w_lit,
    output logic              w_lit_vld
);

    localparam logic [ADDR_W-1:0] RST_ADDR = '1;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              flush;
        logic [LIT_W-1:0]  lit;
        logic              lit_vld;
    } seq_state_t;

    seq_state_t        st_d, st_q;
    nxt_src_e          src;
    logic              push, pop, redirect;
    logic [ADDR_W-1:0] ret_addr, nxt_pc;

    pc_seq_arb u_arb (
        .adv       (adv),
        .do_goto   (do_goto),
        .do_call   (do_call),
        .do_ret    (do_ret),
        .do_pcl_wr (do_pcl_wr),
        .src       (src),
        .push      (push),
        .pop       (pop),
        .redirect  (redirect)
    );

    pc_seq_stack #(.DEPTH(STK_DEPTH), .ADDR_W(ADDR_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .push_val (st_q.pc + 1'b1),
        .top      (ret_addr)
    );

    pc_seq_target #(.ADDR_W(ADDR_W), .LIT_W(LIT_W)) u_target (
        .src      (src),
        .cur      (st_q.pc),
        .op_field (op_field),
        .page_sel (page_sel),
        .dbus     (dbus),
        .ret_addr (ret_addr),
        .nxt      (nxt_pc)
    );

    always_comb begin
        st_d         = st_q;
        st_d.pc      = nxt_pc;
        st_d.flush   = redirect;
        st_d.lit_vld = pop;
        if (pop) st_d.lit = op_field[LIT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc      <= RST_ADDR;
            st_q.flush   <= 1'b0;
            st_q.lit     <= '0;
            st_q.lit_vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_addr = st_q.pc;
    assign flush      = st_q.flush;
    assign w_lit      = st_q.lit;
    assign w_lit_vld  = st_q.lit_vld;

endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk #(
    parameter int ADDR_W = 10,
    parameter int LIT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adv,
    input logic              do_goto,
    input logic              do_call,
    input logic              do_ret,
    input logic              do_pcl_wr,
    input logic [ADDR_W-2:0] op_field,
    input logic              page_sel,
    input logic [LIT_W-1:0]  dbus,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              flush,
    input logic [LIT_W-1:0]  w_lit,
    input logic              w_lit_vld
);

    logic any_br;
    assign any_br = do_goto || do_call || do_ret || do_pcl_wr;

    // R2
    adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !any_br) |=> fetch_addr == $past(fetch_addr) + 1'b1);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !any_br) |=> $stable(fetch_addr));

    // R3
    jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_goto |=> fetch_addr == {$past(page_sel), $past(op_field)});

    // R4
    call_bit8_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_call && !do_goto) |=> fetch_addr[ADDR_W-2] == 1'b0);

    // R5
    low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pcl_wr && !do_goto && !do_call && !do_ret) |=>
            fetch_addr == {$past(page_sel), 1'b0, $past(dbus)});

    // R8
    ret_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_ret && !do_goto && !do_call) |=>
            (w_lit_vld && w_lit == $past(op_field[LIT_W-1:0])));

    // R8
    lit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_ret && !do_goto && !do_call) |=> !w_lit_vld);

    // R9
    flush_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_br |=> flush);

    // R9
    flush_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_br |=> !flush);

endmodule

bind pc_seq pc_seq_chk #(.ADDR_W(ADDR_W), .LIT_W(LIT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .do_goto    (do_goto),
    .do_call    (do_call),
    .do_ret     (do_ret),
    .do_pcl_wr  (do_pcl_wr),
    .op_field   (op_field),
    .page_sel   (page_sel),
    .dbus       (dbus),
    .fetch_addr (fetch_addr),
    .flush      (flush),
    .w_lit      (w_lit),
    .w_lit_vld  (w_lit_vld)
);

// File: tb/pc_seq_test.sv
module pc_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adv = 1'b0, do_goto = 1'b0, do_call = 1'b0;
    logic       do_ret = 1'b0, do_pcl_wr = 1'b0;
    logic [8:0] op_field = '0;
    logic       page_sel = 1'b0;
    logic [7:0] dbus = '0;
    logic [9:0] fetch_addr;
    logic       flush;
    logic [7:0] w_lit;
    logic       w_lit_vld;

    int checks = 0;
    int failures = 0;
    int cyc_cnt = 0;

    always #10 clk = ~clk;

    pc_seq uut (
        .clk(clk), .rst_n(rst_n), .adv(adv), .do_goto(do_goto),
        .do_call(do_call), .do_ret(do_ret), .do_pcl_wr(do_pcl_wr),
        .op_field(op_field), .page_sel(page_sel), .dbus(dbus),
        .fetch_addr(fetch_addr), .flush(flush), .w_lit(w_lit),
        .w_lit_vld(w_lit_vld)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of controls at a falling edge, return at the next one
    task automatic step(input logic a, input logic g, input logic c,
                        input logic r, input logic w, input logic [8:0] op,
                        input logic pg, input logic [7:0] db);
        adv = a; do_goto = g; do_call = c; do_ret = r; do_pcl_wr = w;
        op_field = op; page_sel = pg; dbus = db;
        @(negedge clk);
        adv = 0; do_goto = 0; do_call = 0; do_ret = 0; do_pcl_wr = 0;
    endtask

    task automatic t_reset();
        chk("R1 addr", fetch_addr, 10'h3FF);
        chk("R1 flush", flush, 0);
        chk("R1 vld", w_lit_vld, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 addr after release", fetch_addr, 10'h3FF);
    endtask

    task automatic t_inc();
        step(1,0,0,0,0, 9'h0, 0, 8'h0);
        chk("R2 rollover", fetch_addr, 10'h000);
        chk("R9 no flush on adv", flush, 0);
        step(1,0,0,0,0, 9'h0, 0, 8'h0);
        chk("R2 increment", fetch_addr, 10'h001);
        step(0,0,0,0,0, 9'h0, 0, 8'h0);
        chk("R2 hold", fetch_addr, 10'h001);
    endtask

    task automatic t_goto();
        step(0,1,0,0,0, 9'h1A5, 1, 8'h0);
        chk("R3 jump target", fetch_addr, 10'h3A5);
        chk("R9 flush after jump", flush, 1);
        chk("R8 no literal on jump", w_lit_vld, 0);
        step(0,0,0,0,0, 9'h0, 0, 8'h0);
        chk("R9 flush clears", flush, 0);
        step(0,1,0,0,0, 9'h1FF, 1, 8'h0);
        chk("R3 jump to top", fetch_addr, 10'h3FF);
        step(1,0,0,0,0, 9'h0, 0, 8'h0);
        chk("R2 wrap from top", fetch_addr, 10'h000);
    endtask

    task automatic t_call_ret();
        step(0,1,0,0,0, 9'h010, 0, 8'h0);
        step(0,0,1,0,0, 9'h140, 1, 8'h0);
        chk("R4 call target bit8 clear", fetch_addr, 10'h240);
        chk("R9 flush after call", flush, 1);
        step(0,0,0,1,0, 9'h0AB, 0, 8'h0);
        chk("R6 return address", fetch_addr, 10'h011);
        chk("R8 literal", w_lit, 8'hAB);
        chk("R8 literal valid", w_lit_vld, 1);
        chk("R9 flush after return", flush, 1);
        step(0,0,0,0,0, 9'h0, 0, 8'h0);
        chk("R8 valid one cycle", w_lit_vld, 0);
        step(0,0,0,1,0, 9'h055, 0, 8'h0);
        chk("R6 empty stack gives deep entry", fetch_addr, 10'h000);
    endtask

    task automatic t_overflow();
        step(0,1,0,0,0, 9'h005, 0, 8'h0);
        step(0,0,1,0,0, 9'h020, 0, 8'h0);
        step(0,0,1,0,0, 9'h030, 0, 8'h0);
        step(0,0,1,0,0, 9'h050, 0, 8'h0);
        chk("R4 third call target", fetch_addr, 10'h050);
        step(0,0,0,1,0, 9'h0, 0, 8'h0);
        chk("R7 newest return", fetch_addr, 10'h031);
        step(0,0,0,1,0, 9'h0, 0, 8'h0);
        chk("R7 second return", fetch_addr, 10'h021);
        step(0,0,0,1,0, 9'h0, 0, 8'h0);
        chk("R6 R7 oldest dropped, deep entry repeats", fetch_addr, 10'h021);
    endtask

    task automatic t_pcl();
        step(0,0,1,0,0, 9'h070, 0, 8'h0);
        chk("R4 call from 021", fetch_addr, 10'h070);
        step(0,0,0,0,1, 9'h0, 1, 8'hFE);
        chk("R5 low write target", fetch_addr, 10'h2FE);
        chk("R9 flush after low write", flush, 1);
        step(0,0,0,1,0, 9'h0, 0, 8'h0);
        chk("R5 stack untouched by low write", fetch_addr, 10'h022);
    endtask

    task automatic t_prio();
        step(0,1,1,0,0, 9'h0C3, 0, 8'h0);
        chk("R10 jump beats call", fetch_addr, 10'h0C3);
        step(0,0,0,1,0, 9'h0, 0, 8'h0);
        chk("R10 losing call did not push", fetch_addr, 10'h021);
        step(1,0,1,0,0, 9'h060, 0, 8'h0);
        chk("R10 call beats adv", fetch_addr, 10'h060);
        step(0,0,0,1,1, 9'h012, 0, 8'h77);
        chk("R10 return beats low write", fetch_addr, 10'h022);
        chk("R10 return literal", w_lit, 8'h12);
        step(1,0,0,0,1, 9'h0, 0, 8'h10);
        chk("R10 low write beats adv", fetch_addr, 10'h010);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc_cnt++;
            if (cyc_cnt > 5000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=<5000", cyc_cnt);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_inc();
        t_goto();
        t_call_ret();
        t_overflow();
        t_pcl();
        t_prio();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule